// File: doc/BRIEF.md
# Two's-Complement Execution Unit

This unit performs one operation per accepted request on two W-bit two's-complement operands: addition, subtraction, multiplication, division, six bitwise logic functions, shifts of three kinds in either direction, and increment of the first operand by a small unsigned amount. A request is presented with `inValid` high together with the operands, operation code and shift settings. The registered result appears one clock later with `resValid` high.

Two sticky condition bits, carry and overflow, sit beside the result. A request may set either bit to 1 only if it is an arithmetic or increment operation, the corresponding enable is high, and the operation actually produced a carry or overflow. The unit never clears these bits; only reset does. Division by zero does not touch the condition bits. Instead, it returns all ones and pulses a per-result error bit.

Top module: `exec_unit`

## Requirements
- R1: After reset `result` is 0 and `resValid`, `divErr`, `carryFlag` and `ovflFlag` are all 0.
- R2: Operation codes are 0 add, 1 subtract (A minus B), 2 multiply, 3 divide, 4 and, 5 or, 6 nand, 7 nor, 8 xor, 9 not (of A), 10 shift (of A), 11 increment. Add and subtract wrap modulo 2^W. A request accepted at a clock edge with `inValid` high drives its result and `resValid` high after that edge; with `inValid` low, `resValid` is 0 after the edge.
- R3: `carryFlag` becomes 1 only when `carryEn` is high on an add (unsigned carry out), a subtract (borrow, i.e. unsigned A < B) or an increment (unsigned carry out). Once set, it stays 1 until reset.
- R4: `ovflFlag` becomes 1 only when `ovflEn` is high on an add, subtract, multiply, divide or increment whose signed result does not fit in W bits. Once set, it stays 1 until reset.
- R5: Multiply returns the low W bits of the signed product and reports overflow when the full product lies outside the signed W-bit range.
- R6: Divide returns the signed quotient truncated toward zero. The most negative value divided by -1 returns the most negative value and reports overflow.
- R7: Divide with B equal to 0 returns all ones with `divErr` high for that result, and leaves both condition bits unchanged. `divErr` is 0 for every other result.
- R8: Codes 4 to 9 return A&B, A|B, ~(A&B), ~(A|B), A^B and ~A.
- R9: `shiftKind` 0 is logical, 1 is arithmetic, 2 is cyclic, and 3 acts as logical. `shiftLeft` 1 shifts left. An amount of W or more gives 0 for logical shifts and for arithmetic left shifts, and sign fill for arithmetic right shifts. Cyclic shifts rotate by the amount modulo W.
- R10: Increment returns A plus `amount` zero-extended, modulo 2^W. Signed overflow is reported when a non-negative A becomes negative.
- R11: Logic, shift and undefined codes (12 to 15) never change the condition bits. Undefined codes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present this cycle |
| opCode | input | 4 | Operation code (R2) |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| shiftKind | input | 2 | Shift type (R9) |
| shiftLeft | input | 1 | Shift direction, 1 = left |
| amount | input | $clog2(W)+1 | Shift or increment amount |
| carryEn | input | 1 | Allow this request to set the carry bit |
| ovflEn | input | 1 | Allow this request to set the overflow bit |
| result | output | W | Registered result |
| resValid | output | 1 | Result valid |
| divErr | output | 1 | Current result came from division by zero |
| carryFlag | output | 1 | Sticky carry / borrow bit |
| ovflFlag | output | 1 | Sticky signed overflow bit |

## Verification
The hardest condition to reach is a condition-bit rise. Both bits are sticky, so after the first qualifying carry or overflow, no later request can show whether a flag would have been set. The stimulus therefore runs in short random bursts, each preceded by a reset, so the bits start from 0 many times. Operands are biased toward the extreme values, which makes carries, signed overflows and the quotient overflow of the most negative value divided by -1 frequent. Directed cases cover division by zero with both enables high, and shift amounts of exactly W and beyond.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_MUL   = 4'd2,
    OP_DIV   = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_NAND  = 4'd6,
    OP_NOR   = 4'd7,
    OP_XOR   = 4'd8,
    OP_NOT   = 4'd9,
    OP_SHIFT = 4'd10,
    OP_INC   = 4'd11
  } opcode_e;

  typedef enum logic [1:0] {
    SH_LOGIC = 2'd0,
    SH_ARITH = 2'd1,
    SH_CYCLE = 2'd2
  } shkind_e;

  typedef enum logic [2:0] {
    U_NONE,
    U_ADDSUB,
    U_MUL,
    U_DIV,
    U_LOGIC,
    U_SHIFT,
    U_INC
  } unit_e;

  typedef enum logic [2:0] {
    L_AND,
    L_OR,
    L_NAND,
    L_NOR,
    L_XOR,
    L_NOT
  } logic_e;

  typedef struct packed {
    unit_e  unit;
    logic   isSub;
    logic_e logicSel;
    logic   carryWr;
    logic   ovflWr;
    logic   load;
  } strobe_t;

endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic       inValid,
  input  logic [3:0] opCode,
  input  logic       carryEn,
  input  logic       ovflEn,
  output strobe_t    strobe
);

  logic carryKind;
  logic ovflKind;

  always_comb begin
    strobe.unit     = U_NONE;
    strobe.isSub    = 1'b0;
    strobe.logicSel = L_AND;
    carryKind       = 1'b0;
    ovflKind        = 1'b0;
    case (opCode)
      OP_ADD:   begin strobe.unit = U_ADDSUB; carryKind = 1'b1; ovflKind = 1'b1; end
      OP_SUB:   begin strobe.unit = U_ADDSUB; strobe.isSub = 1'b1; carryKind = 1'b1; ovflKind = 1'b1; end
      OP_MUL:   begin strobe.unit = U_MUL; ovflKind = 1'b1; end
      OP_DIV:   begin strobe.unit = U_DIV; ovflKind = 1'b1; end
      OP_AND:   begin strobe.unit = U_LOGIC; strobe.logicSel = L_AND; end
      OP_OR:    begin strobe.unit = U_LOGIC; strobe.logicSel = L_OR; end
      OP_NAND:  begin strobe.unit = U_LOGIC; strobe.logicSel = L_NAND; end
      OP_NOR:   begin strobe.unit = U_LOGIC; strobe.logicSel = L_NOR; end
      OP_XOR:   begin strobe.unit = U_LOGIC; strobe.logicSel = L_XOR; end
      OP_NOT:   begin strobe.unit = U_LOGIC; strobe.logicSel = L_NOT; end
      OP_SHIFT: strobe.unit = U_SHIFT;
      OP_INC:   begin strobe.unit = U_INC; carryKind = 1'b1; ovflKind = 1'b1; end
      default:  strobe.unit = U_NONE;
    endcase
    strobe.load    = inValid;
    strobe.carryWr = inValid && carryEn && carryKind;
    strobe.ovflWr  = inValid && ovflEn && ovflKind;
  end

endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [3:0]    opCode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [1:0]    shiftKind,
  input  logic          shiftLeft,
  input  logic [AW-1:0] amount,
  output logic [W-1:0]  result,
  output logic          resValid,
  output logic          divErr,
  output logic          carryFlag,
  output logic          ovflFlag
);

  localparam int PW = 2 * W;

  // add / subtract
  logic [W-1:0] bEff;
  logic [W:0]   addSum;
  logic         addOvfl;
  assign bEff    = strobe.isSub ? ~opB : opB;
  assign addSum  = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, strobe.isSub};
  assign addOvfl = (opA[W-1] == bEff[W-1]) && (addSum[W-1] != opA[W-1]);

  // increment
  logic [W:0] incSum;
  assign incSum = {1'b0, opA} + {{(W+1-AW){1'b0}}, amount};

  // multiply
  logic [PW-1:0] prod;
  logic          mulOvfl;
  assign prod    = $signed({{W{opA[W-1]}}, opA}) * $signed({{W{opB[W-1]}}, opB});
  assign mulOvfl = !((&prod[PW-1:W-1]) || !(|prod[PW-1:W-1]));

  // divide, one extra bit holds the MIN / -1 quotient
  logic         divZero;
  logic [W:0]   numX, denX, quo;
  logic         divOvfl;
  assign divZero = (opB == '0);
  assign numX    = {opA[W-1], opA};
  assign denX    = divZero ? {{W{1'b0}}, 1'b1} : {opB[W-1], opB};
  assign quo     = $signed(numX) / $signed(denX);
  assign divOvfl = !divZero && (quo[W] != quo[W-1]);

  // shifts
  logic          bigAmt;
  logic [AW-1:0] rotAmt;
  logic [PW-1:0] dbl, rolV, rorV;
  logic [W-1:0]  shRes;
  assign bigAmt = amount >= AW'(W);
  assign rotAmt = AW'(amount % AW'(W));
  assign dbl    = {opA, opA};
  assign rolV   = dbl << rotAmt;
  assign rorV   = dbl >> rotAmt;

  always_comb begin
    if (shiftKind == SH_CYCLE) begin
      shRes = shiftLeft ? rolV[PW-1:W] : rorV[W-1:0];
    end else if (bigAmt) begin
      shRes = (shiftKind == SH_ARITH && !shiftLeft) ? {W{opA[W-1]}} : '0;
    end else if (shiftLeft) begin
      shRes = opA << amount;
    end else if (shiftKind == SH_ARITH) begin
      shRes = $signed(opA) >>> amount;
    end else begin
      shRes = opA >> amount;
    end
  end

  // logic
  logic [W-1:0] logRes;
  always_comb begin
    case (strobe.logicSel)
      L_AND:   logRes = opA & opB;
      L_OR:    logRes = opA | opB;
      L_NAND:  logRes = ~(opA & opB);
      L_NOR:   logRes = ~(opA | opB);
      L_XOR:   logRes = opA ^ opB;
      default: logRes = ~opA;
    endcase
  end

  // result select and raw flag outcomes
  logic [W-1:0] nextRes;
  logic         rawCarry, rawOvfl;
  always_comb begin
    nextRes  = '0;
    rawCarry = 1'b0;
    rawOvfl  = 1'b0;
    case (strobe.unit)
      U_ADDSUB: begin
        nextRes  = addSum[W-1:0];
        rawCarry = strobe.isSub ? !addSum[W] : addSum[W];
        rawOvfl  = addOvfl;
      end
      U_MUL:   begin nextRes = prod[W-1:0]; rawOvfl = mulOvfl; end
      U_DIV:   begin nextRes = divZero ? '1 : quo[W-1:0]; rawOvfl = divOvfl; end
      U_LOGIC: nextRes = logRes;
      U_SHIFT: nextRes = shRes;
      U_INC: begin
        nextRes  = incSum[W-1:0];
        rawCarry = incSum[W];
        rawOvfl  = !opA[W-1] && incSum[W-1];
      end
      default: nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      resValid  <= 1'b0;
      divErr    <= 1'b0;
      carryFlag <= 1'b0;
      ovflFlag  <= 1'b0;
    end else begin
      resValid <= strobe.load;
      if (strobe.load) begin
        result <= nextRes;
        divErr <= (strobe.unit == U_DIV) && divZero;
      end else begin
        divErr <= 1'b0;
      end
      if (strobe.carryWr && rawCarry) carryFlag <= 1'b1;
      if (strobe.ovflWr && rawOvfl)   ovflFlag  <= 1'b1;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(strobe.load));

  p_carry_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carryFlag) |-> $past(strobe.carryWr));

  p_ovfl_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovflFlag) |-> $past(strobe.ovflWr));

  p_div_zero_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> (result == '1));

  p_div_zero_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> $past(strobe.load && opCode == OP_DIV && opB == '0));

  p_flags_kept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (strobe.unit == U_LOGIC || strobe.unit == U_SHIFT || strobe.unit == U_NONE))
      |=> ($stable(carryFlag) && $stable(ovflFlag)));

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int W = 16,
  localparam int AW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [3:0]    opCode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [1:0]    shiftKind,
  input  logic          shiftLeft,
  input  logic [AW-1:0] amount,
  input  logic          carryEn,
  input  logic          ovflEn,
  output logic [W-1:0]  result,
  output logic          resValid,
  output logic          divErr,
  output logic          carryFlag,
  output logic          ovflFlag
);

  strobe_t strobe;

  exec_ctrl u_ctrl (
    .inValid (inValid),
    .opCode  (opCode),
    .carryEn (carryEn),
    .ovflEn  (ovflEn),
    .strobe  (strobe)
  );

  exec_datapath #(.W(W), .AW(AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opCode    (opCode),
    .opA       (opA),
    .opB       (opB),
    .shiftKind (shiftKind),
    .shiftLeft (shiftLeft),
    .amount    (amount),
    .result    (result),
    .resValid  (resValid),
    .divErr    (divErr),
    .carryFlag (carryFlag),
    .ovflFlag  (ovflFlag)
  );

endmodule

// File: tb/exec_unit_test.sv
module exec_unit_test;

  localparam int W  = 16;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [3:0]    opCode = '0;
  logic [W-1:0]  opA = '0, opB = '0;
  logic [1:0]    shiftKind = '0;
  logic          shiftLeft = 1'b0;
  logic [AW-1:0] amount = '0;
  logic          carryEn = 1'b0, ovflEn = 1'b0;
  logic [W-1:0]  result;
  logic          resValid, divErr, carryFlag, ovflFlag;

  int  total = 0;
  int  bad = 0;
  bit  expC = 0, expV = 0;

  always #5 clk = ~clk;

  exec_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .opA(opA), .opB(opB), .shiftKind(shiftKind), .shiftLeft(shiftLeft),
    .amount(amount), .carryEn(carryEn), .ovflEn(ovflEn),
    .result(result), .resValid(resValid), .divErr(divErr),
    .carryFlag(carryFlag), .ovflFlag(ovflFlag)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [1:0] k, input bit lft, input int amt,
                       output logic [15:0] r, output bit c, output bit v, output bit e);
    longint s;
    int rr;
    c = 0; v = 0; e = 0; r = 0;
    case (op)
      0: begin s = longint'(a) + longint'(b); r = s[15:0]; c = s > 65535;
               s = sx(a) + sx(b); v = (s > 32767) || (s < -32768); end
      1: begin r = a - b; c = a < b;
               s = sx(a) - sx(b); v = (s > 32767) || (s < -32768); end
      2: begin s = sx(a) * sx(b); r = s[15:0]; v = (s > 32767) || (s < -32768); end
      3: if (b == 0) begin r = 16'hffff; e = 1; end
         else begin s = sx(a) / sx(b); r = s[15:0]; v = (s > 32767); end
      4: r = a & b;
      5: r = a | b;
      6: r = ~(a & b);
      7: r = ~(a | b);
      8: r = a ^ b;
      9: r = ~a;
      10: begin
        if (k == 2) begin
          rr = amt % 16;
          r = lft ? ((a << rr) | (a >> (16 - rr))) : ((a >> rr) | (a << (16 - rr)));
        end else if (lft) r = (amt >= 16) ? 16'h0 : a << amt;
        else if (k == 1) r = (amt >= 16) ? {16{a[15]}} : 16'($signed(a) >>> amt);
        else r = (amt >= 16) ? 16'h0 : a >> amt;
      end
      11: begin s = longint'(a) + amt; r = s[15:0]; c = s > 65535;
                v = (sx(a) + amt) > 32767; end
      default: r = 0;
    endcase
  endtask

  function automatic string resTag(input logic [3:0] op, input logic [15:0] b);
    case (op)
      0, 1: return "R2 add/sub result";
      2: return "R5 multiply result";
      3: return (b == 0) ? "R7 divide-by-zero result" : "R6 divide result";
      4, 5, 6, 7, 8, 9: return "R8 logic result";
      10: return "R9 shift result";
      11: return "R10 increment result";
      default: return "R11 undefined code result";
    endcase
  endfunction

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0;
    repeat (2) @(negedge clk);
    chk(result == 0 && !resValid && !divErr && !carryFlag && !ovflFlag,
        "R1 reset state", {result, resValid, divErr, carryFlag, ovflFlag}, 0);
    rstN = 1'b1;
    expC = 0; expV = 0;
    @(negedge clk);
    chk(!resValid, "R2 idle gives no valid", resValid, 0);
  endtask

  task automatic doOp(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                      input logic [1:0] k, input bit lft, input int amt,
                      input bit ce, input bit oe);
    logic [15:0] r; bit c, v, e;
    bit flagless;
    opCode = op; opA = a; opB = b; shiftKind = k; shiftLeft = lft;
    amount = AW'(amt); carryEn = ce; ovflEn = oe; inValid = 1'b1;
    model(op, a, b, k, lft, amt, r, c, v, e);
    if (ce && c && (op <= 1 || op == 11)) expC = 1;
    if (oe && v && (op <= 3 || op == 11)) expV = 1;
    flagless = (op >= 4 && op <= 10) || op >= 12;
    @(negedge clk);
    inValid = 1'b0;
    chk(resValid == 1'b1, "R2 result valid", resValid, 1);
    chk(result == r, resTag(op, b), result, r);
    chk(divErr == e, "R7 divide error bit", divErr, e);
    chk(carryFlag == expC, flagless ? "R11 carry kept" : "R3 carry bit", carryFlag, expC);
    chk(ovflFlag == expV, flagless ? "R11 overflow kept" : "R4 overflow bit", ovflFlag, expV);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 6)
      0: return 16'h7fff;
      1: return 16'h8000;
      2: return 16'hffff;
      3: return 16'h0000 + 16'($urandom % 4);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2718));
    doReset();
    // directed corners
    doOp(0, 16'h7fff, 16'h0001, 0, 0, 0, 0, 0);   // R4 disabled: no flag
    doOp(0, 16'h7fff, 16'h0001, 0, 0, 0, 0, 1);   // R4 signed overflow
    doOp(0, 16'hffff, 16'h0001, 0, 0, 0, 1, 0);   // R3 carry out
    doReset();
    doOp(1, 16'h0003, 16'h0005, 0, 0, 0, 1, 1);   // R3 borrow
    doReset();
    doOp(3, 16'h1234, 16'h0000, 0, 0, 0, 1, 1);   // R7 div by zero, flags stay 0
    doOp(3, 16'hfff9, 16'h0002, 0, 0, 0, 1, 1);   // R6 -7/2 = -3
    doOp(3, 16'h8000, 16'hffff, 0, 0, 0, 0, 1);   // R6 MIN / -1
    doReset();
    doOp(2, 16'h0100, 16'h0100, 0, 0, 0, 1, 1);   // R5 overflow, carry untouched
    doOp(2, 16'hfffd, 16'h0007, 0, 0, 0, 0, 0);   // R5 -21
    doOp(10, 16'h8421, 0, 0, 1, 16, 0, 0);        // R9 logical left by W
    doOp(10, 16'h8421, 0, 1, 0, 16, 0, 0);        // R9 arith right by W
    doOp(10, 16'h8421, 0, 1, 0, 31, 0, 0);        // R9 arith right beyond W
    doOp(10, 16'h8421, 0, 1, 1, 3, 0, 0);         // R9 arith left
    doOp(10, 16'h8421, 0, 2, 1, 17, 0, 0);        // R9 cyclic mod W
    doOp(10, 16'h8421, 0, 2, 0, 4, 0, 0);         // R9 cyclic right
    doOp(10, 16'h8421, 0, 3, 0, 2, 0, 0);         // R9 kind 3 logical
    doReset();
    doOp(11, 16'h7ffe, 0, 0, 0, 31, 1, 1);        // R10 signed overflow
    doOp(11, 16'hfff0, 0, 0, 0, 31, 1, 1);        // R10 carry out
    doReset();
    doOp(13, 16'hffff, 16'hffff, 0, 0, 0, 1, 1);  // R11 undefined code
    doOp(9, 16'h00f0, 16'h0, 0, 0, 0, 1, 1);      // R8 not
    // random bursts, each starting from cleared flags
    for (int burst = 0; burst < 60; burst++) begin
      doReset();
      for (int i = 0; i < 25; i++) begin
        doOp(4'($urandom % 16), pick(), pick(), 2'($urandom % 4), 1'($urandom % 2),
             int'($urandom % 32), 1'($urandom % 2), 1'($urandom % 2));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule